// File: doc/BRIEF.md
# Barrel-Shifter Carrier Scheduler

This block sits at the sending side of one source in an N-by-N event-building fabric. It keeps a separate queue for every destination and accepts message words through a single write port. Each word carries a destination tag and start and end-of-message markers. In every time slot the block sends one fixed-size carrier: a header beat followed by exactly `CARRIER_W` payload beats. It then moves on to the next destination in a fixed cyclic order. Each source instance starts its rotation at its own destination index, `SRC_ID`, so the sources in the fabric address disjoint destinations in every slot. No shared arbiter or synchronising signal is needed.

Messages flow straight through carrier boundaries. A long message continues in the next carrier for the same destination, one rotation later. One carrier may end one message and start the next. A destination with nothing queued still receives its slot, as a header announcing zero words, so the rotation phase never drifts. The only pacing is a per-destination ready line from the link. If the ready line of the current destination is low at the start of its slot, the whole rotation waits there.

The control is a three-state machine:
- `S_BOOT` is the single cycle after reset and moves unconditionally to `S_SLOT`.
- `S_SLOT` emits the header when the current destination is ready and moves to `S_PAY`. Otherwise it stays in `S_SLOT`.
- `S_PAY` emits the payload beats. After the last beat it advances the destination and returns to `S_SLOT`.

Top module: `bs_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `car_valid` is 0. The first header after reset addresses destination `SRC_ID`.
- R2: A header beat (`car_valid`=1, `car_hdr`=1) is always followed, on the next `CARRIER_W` consecutive cycles, by payload beats (`car_valid`=1, `car_hdr`=0). No beat is emitted outside a carrier.
- R3: Successive headers address destinations `SRC_ID`, `SRC_ID`+1, … `N_DEST`-1, 0, 1, … in strict cyclic order.
- R4: `hdr_count` equals the smaller of the destination queue's occupancy in the header cycle and `CARRIER_W`. The first `hdr_count` payload beats have `pay_valid`=1 and the remaining beats have `pay_valid`=0. An empty queue still gets a header with count 0.
- R5: Words of one destination leave in the order they were written, regardless of writes to other destinations. A message longer than the words sent in one carrier continues in that destination's next carrier.
- R6: Each payload word keeps its start (`pay_sop`) and end (`pay_eop`) markers from the write port, so one carrier can hold the end of one message and the start of the next.
- R7: If `dest_ready` of the current destination is 0 in the slot cycle, no header is sent and the rotation holds that destination until its ready line returns to 1. The ready line is not consulted during payload beats.
- R8: A write to a destination whose queue already holds `QDEPTH` words is discarded. `err_overflow` is 1 in the following cycle and 0 after cycles without such a write.
- R9: Every header carries `hdr_src` = `SRC_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe for one message word |
| wr_dest | input | $clog2(N_DEST) | Destination queue of the written word |
| wr_data | input | DATA_W | Message word |
| wr_sop | input | 1 | Word is the first of its message |
| wr_eop | input | 1 | Word is the last of its message |
| dest_ready | input | N_DEST | Per-destination link ready (backpressure) |
| car_valid | output | 1 | A carrier beat is present |
| car_hdr | output | 1 | The beat is a header |
| hdr_src | output | $clog2(N_DEST) | Source index on header beats, else 0 |
| hdr_dest | output | $clog2(N_DEST) | Destination index on header beats, else 0 |
| hdr_count | output | $clog2(CARRIER_W+1) | Valid payload words in this carrier, on header beats |
| pay_valid | output | 1 | Payload beat carries a queued word |
| pay_data | output | DATA_W | Payload word, 0 when not valid |
| pay_sop | output | 1 | Payload word starts a message |
| pay_eop | output | 1 | Payload word ends a message |
| err_overflow | output | 1 | A write was dropped at a full queue in the previous cycle |

## Verification
The bench runs a small configuration: four destinations, four-word carriers, eight-deep queues, and a non-zero source index. It sweeps message lengths from one word to more than two carriers into every destination while the ready lines follow a shifting pattern.
- A design that resumed rotation at the wrong destination after a stall, or skipped a stalled slot, would break the expected destination sequence.
- A design that counted words written during a carrier into that carrier's header would report a count that does not match the payload.
- A design that lost the continuation of long messages would drop or reorder words.
- Filling one queue past its depth while every link is held off checks two things: the discarded words never appear downstream, and the error pulse lands exactly one cycle after each rejected write.

// File: rtl/bs_pkg.sv
package bs_pkg;

    typedef enum logic [1:0] {
        S_BOOT = 2'd0,
        S_SLOT = 2'd1,
        S_PAY  = 2'd2
    } slot_state_t;

endpackage

// File: rtl/bs_fifo.sv
module bs_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [OW-1:0] occ,
    output logic          ovf
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [OW-1:0] occ_q;
    logic          full, do_push;

    assign full    = (occ_q == OW'(DEPTH));
    assign do_push = push && !full;
    assign ovf     = push && full;
    assign occ     = occ_q;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            occ_q <= occ_q + OW'(do_push) - OW'(pop);
        end
    end

endmodule

// File: rtl/bs_carrier_fsm.sv
module bs_carrier_fsm
    import bs_pkg::*;
#(
    parameter int N_DEST    = 8,
    parameter int CARRIER_W = 16,
    parameter int SRC_ID    = 0,
    parameter int OW        = 6,
    localparam int DW       = $clog2(N_DEST),
    localparam int CW       = $clog2(CARRIER_W + 1),
    localparam int BW       = $clog2(CARRIER_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] cur_occ,
    input  logic          cur_ready,
    output logic [DW-1:0] cur_dest,
    output logic          car_valid,
    output logic          car_hdr,
    output logic [CW-1:0] hdr_count,
    output logic          pay_valid,
    output logic          pop
);

    slot_state_t   state_q, state_d;
    logic [DW-1:0] cur_q, cur_d;
    logic [BW-1:0] beat_q, beat_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] slot_count;
    logic          last_beat;

    // Words granted to this carrier: queue occupancy capped at the carrier size
    always_comb begin
        int occ_i;
        occ_i      = int'(cur_occ);
        slot_count = CW'((occ_i > CARRIER_W) ? CARRIER_W : occ_i);
    end

    assign last_beat = (beat_q == BW'(CARRIER_W - 1));
    assign cur_dest  = cur_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_BOOT;
            cur_q   <= DW'(SRC_ID % N_DEST);
            beat_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            beat_q  <= beat_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        beat_d  = beat_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_BOOT: begin
                state_d = S_SLOT;
            end
            S_SLOT: begin
                if (cur_ready) begin
                    state_d = S_PAY;
                    beat_d  = '0;
                    cnt_d   = slot_count;
                end
            end
            S_PAY: begin
                if (last_beat) begin
                    state_d = S_SLOT;
                    cur_d   = (cur_q == DW'(N_DEST - 1)) ? '0 : cur_q + 1'b1;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            default: begin
                state_d = S_BOOT;
            end
        endcase
    end

    // Output logic
    always_comb begin
        car_valid = 1'b0;
        car_hdr   = 1'b0;
        hdr_count = '0;
        pay_valid = 1'b0;
        unique case (state_q)
            S_BOOT: begin
            end
            S_SLOT: begin
                car_valid = cur_ready;
                car_hdr   = cur_ready;
                hdr_count = cur_ready ? slot_count : '0;
            end
            S_PAY: begin
                car_valid = 1'b1;
                pay_valid = (int'(beat_q) < int'(cnt_q));
            end
            default: begin
            end
        endcase
        pop = pay_valid;
    end

endmodule

// File: rtl/bs_sched.sv
module bs_sched #(
    parameter int N_DEST    = 8,
    parameter int CARRIER_W = 16,
    parameter int QDEPTH    = 32,
    parameter int DATA_W    = 16,
    parameter int SRC_ID    = 0,
    localparam int DW       = $clog2(N_DEST),
    localparam int CW       = $clog2(CARRIER_W + 1),
    localparam int OW       = $clog2(QDEPTH + 1),
    localparam int EW       = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DW-1:0]     wr_dest,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [N_DEST-1:0] dest_ready,
    output logic              car_valid,
    output logic              car_hdr,
    output logic [DW-1:0]     hdr_src,
    output logic [DW-1:0]     hdr_dest,
    output logic [CW-1:0]     hdr_count,
    output logic              pay_valid,
    output logic [DATA_W-1:0] pay_data,
    output logic              pay_sop,
    output logic              pay_eop,
    output logic              err_overflow
);

    logic [EW-1:0]     head_arr [N_DEST];
    logic [OW-1:0]     occ_arr  [N_DEST];
    logic [N_DEST-1:0] ovf_vec;
    logic [DW-1:0]     cur_dest;
    logic              fsm_pop;
    logic [EW-1:0]     head;
    logic              err_q;

    // One queue per destination; each entry packs {data, sop, eop}
    for (genvar g = 0; g < N_DEST; g++) begin : g_queue
        logic push_g, pop_g;
        assign push_g = wr_valid && (wr_dest == DW'(g));
        assign pop_g  = fsm_pop && (cur_dest == DW'(g));

        bs_fifo #(
            .W     (EW),
            .DEPTH (QDEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_g),
            .din   ({wr_data, wr_sop, wr_eop}),
            .pop   (pop_g),
            .dout  (head_arr[g]),
            .occ   (occ_arr[g]),
            .ovf   (ovf_vec[g])
        );
    end

    bs_carrier_fsm #(
        .N_DEST    (N_DEST),
        .CARRIER_W (CARRIER_W),
        .SRC_ID    (SRC_ID),
        .OW        (OW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_occ   (occ_arr[cur_dest]),
        .cur_ready (dest_ready[cur_dest]),
        .cur_dest  (cur_dest),
        .car_valid (car_valid),
        .car_hdr   (car_hdr),
        .hdr_count (hdr_count),
        .pay_valid (pay_valid),
        .pop       (fsm_pop)
    );

    assign head     = head_arr[cur_dest];
    assign pay_data = pay_valid ? head[EW-1:2] : '0;
    assign pay_sop  = pay_valid && head[1];
    assign pay_eop  = pay_valid && head[0];
    assign hdr_src  = car_hdr ? DW'(SRC_ID % N_DEST) : '0;
    assign hdr_dest = car_hdr ? cur_dest : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= |ovf_vec;
        end
    end

    assign err_overflow = err_q;

endmodule

// File: rtl/bs_sched_chk.sv
module bs_sched_chk #(
    parameter int N_DEST    = 8,
    parameter int CARRIER_W = 16,
    parameter int SRC_ID    = 0,
    localparam int DW       = $clog2(N_DEST),
    localparam int CW       = $clog2(CARRIER_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [N_DEST-1:0] dest_ready,
    input logic              car_valid,
    input logic              car_hdr,
    input logic [DW-1:0]     hdr_src,
    input logic [DW-1:0]     hdr_dest,
    input logic [CW-1:0]     hdr_count,
    input logic              pay_valid,
    input logic              err_overflow
);

    logic          in_car_q;
    int            beats_q;
    logic          seen_q;
    logic [DW-1:0] last_q;
    logic [DW-1:0] next_dest;

    assign next_dest = (last_q == DW'(N_DEST - 1)) ? '0 : last_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_car_q <= 1'b0;
            beats_q  <= 0;
            seen_q   <= 1'b0;
            last_q   <= '0;
        end else begin
            if (car_hdr) begin
                in_car_q <= 1'b1;
                beats_q  <= 0;
                seen_q   <= 1'b1;
                last_q   <= hdr_dest;
            end else if (in_car_q && car_valid) begin
                beats_q <= beats_q + 1;
                if (beats_q == CARRIER_W - 1) begin
                    in_car_q <= 1'b0;
                end
            end
        end
    end

    // R2
    pay_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_car_q |-> (car_valid && !car_hdr));

    // R2
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_car_q && car_valid) |-> car_hdr);

    // R3
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_hdr && seen_q) |-> (hdr_dest == next_dest));

    // R1
    first_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_hdr && !seen_q) |-> (hdr_dest == DW'(SRC_ID % N_DEST)));

    // R4
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        car_hdr |-> (int'(hdr_count) <= CARRIER_W));

    // R4
    pay_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (in_car_q && car_valid && !car_hdr));

    // R7
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        car_hdr |-> dest_ready[hdr_dest]);

    // R8
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> $past(wr_valid));

    // R9
    src_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        car_hdr |-> (hdr_src == DW'(SRC_ID % N_DEST)));

endmodule

bind bs_sched bs_sched_chk #(
    .N_DEST    (N_DEST),
    .CARRIER_W (CARRIER_W),
    .SRC_ID    (SRC_ID)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .dest_ready   (dest_ready),
    .car_valid    (car_valid),
    .car_hdr      (car_hdr),
    .hdr_src      (hdr_src),
    .hdr_dest     (hdr_dest),
    .hdr_count    (hdr_count),
    .pay_valid    (pay_valid),
    .err_overflow (err_overflow)
);

// File: tb/bs_sched_bench.sv
module bs_sched_bench;

    localparam int N   = 4;
    localparam int CWD = 4;
    localparam int QD  = 8;
    localparam int DWD = 12;
    localparam int SRC = 2;
    localparam int DW  = $clog2(N);
    localparam int CW  = $clog2(CWD + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_valid = 1'b0;
    logic [DW-1:0]  wr_dest = '0;
    logic [DWD-1:0] wr_data = '0;
    logic           wr_sop = 1'b0;
    logic           wr_eop = 1'b0;
    logic [N-1:0]   dest_ready = '1;
    logic           car_valid, car_hdr, pay_valid, pay_sop, pay_eop, err_overflow;
    logic [DW-1:0]  hdr_src, hdr_dest;
    logic [CW-1:0]  hdr_count;
    logic [DWD-1:0] pay_data;

    bs_sched #(
        .N_DEST(N), .CARRIER_W(CWD), .QDEPTH(QD), .DATA_W(DWD), .SRC_ID(SRC)
    ) u_bs_sched (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_dest(wr_dest),
        .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .dest_ready(dest_ready), .car_valid(car_valid), .car_hdr(car_hdr),
        .hdr_src(hdr_src), .hdr_dest(hdr_dest), .hdr_count(hdr_count),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_sop(pay_sop),
        .pay_eop(pay_eop), .err_overflow(err_overflow)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: per-destination queues of {data, sop, eop}
    int mq [N][64];
    int mh [N];
    int mt [N];
    bit booted = 0;
    int beat_left = 0;
    int cur_cnt = 0;
    int exp_dest = SRC;
    bit exp_err = 0;

    function automatic int mocc(input int d);
        return mt[d] - mh[d];
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            booted    = 0;
            beat_left = 0;
            exp_dest  = SRC;
            exp_err   = 0;
            chk(car_valid == 1'b0, "R1 valid in reset", int'(car_valid), 0);
        end else begin
            int occ_before [N];
            for (int d = 0; d < N; d++) occ_before[d] = mocc(d);
            if (!booted) begin
                chk(car_valid == 1'b0, "R1 boot cycle", int'(car_valid), 0);
                booted = 1;
            end else if (beat_left > 0) begin
                int idx;
                bit ev;
                idx = CWD - beat_left;
                chk(car_valid && !car_hdr, "R2 payload beat", int'(car_hdr), 0);
                ev = (idx < cur_cnt);
                chk(pay_valid == ev, "R4 pay_valid", int'(pay_valid), int'(ev));
                if (ev) begin
                    int e;
                    e = mq[exp_dest][mh[exp_dest] % 64];
                    mh[exp_dest]++;
                    chk(int'(pay_data) == (e >> 2), "R5 word order", int'(pay_data), e >> 2);
                    chk({pay_sop, pay_eop} == 2'(e & 3), "R6 boundary flags",
                        int'({pay_sop, pay_eop}), e & 3);
                end
                beat_left--;
                if (beat_left == 0) exp_dest = (exp_dest + 1) % N;
            end else begin
                bit eh;
                eh = dest_ready[exp_dest];
                chk(car_hdr == eh && car_valid == eh,
                    eh ? "R2 header expected" : "R7 stalled slot", int'(car_hdr), int'(eh));
                if (car_hdr) begin
                    int ec;
                    ec = (mocc(exp_dest) > CWD) ? CWD : mocc(exp_dest);
                    chk(int'(hdr_dest) == exp_dest, "R3 rotation", int'(hdr_dest), exp_dest);
                    chk(int'(hdr_src) == SRC, "R9 source id", int'(hdr_src), SRC);
                    chk(int'(hdr_count) == ec, "R4 header count", int'(hdr_count), ec);
                    cur_cnt   = ec;
                    beat_left = CWD;
                end
            end
            chk(err_overflow == exp_err, "R8 overflow flag", int'(err_overflow), int'(exp_err));
            exp_err = 0;
            if (wr_valid) begin
                int d;
                d = int'(wr_dest);
                if (occ_before[d] >= QD) begin
                    exp_err = 1;
                end else begin
                    mq[d][mt[d] % 64] = (int'(wr_data) << 2) | (int'(wr_sop) << 1) | int'(wr_eop);
                    mt[d]++;
                end
            end
        end
    end

    // Ready-line driver: 0 all ready, 1 shifting pattern, 2 all held off
    int rmode = 0;
    int cyc = 0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            for (int d = 0; d < N; d++) begin
                if (rmode == 0) dest_ready[d] = 1'b1;
                else if (rmode == 1) dest_ready[d] = (((cyc * 3) + d) % 7) != 0;
                else dest_ready[d] = 1'b0;
            end
        end
    end

    task automatic put(input int d, input int data, input bit sop, input bit eop, input bit raw);
        if (!raw) begin
            while (mocc(d) >= QD) begin
                @(posedge clk);
                #1;
            end
        end
        wr_valid = 1'b1;
        wr_dest  = DW'(d);
        wr_data  = DWD'(data);
        wr_sop   = sop;
        wr_eop   = eop;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        bit busy;
        busy = 1;
        while (busy) begin
            busy = 0;
            for (int d = 0; d < N; d++) if (mocc(d) != 0) busy = 1;
            @(posedge clk);
            #1;
        end
        repeat (2 * N * (CWD + 1)) @(posedge clk);
        #1;
    endtask

    initial begin
        for (int d = 0; d < N; d++) begin
            mh[d] = 0;
            mt[d] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R4: empty queues still produce zero-count carriers in rotation
        repeat (3 * N * (CWD + 1)) @(posedge clk);
        #1;
        // R5 R6: message length sweep over all destinations, links always ready
        for (int len = 1; len <= 9; len++) begin
            for (int d = 0; d < N; d++) begin
                for (int k = 0; k < len; k++) begin
                    put(d, (len * 64 + d * 16 + k) % 4096, k == 0, k == len - 1, 0);
                end
            end
        end
        drain();
        // R7: same sweep under shifting backpressure
        rmode = 1;
        for (int len = 1; len <= 9; len++) begin
            for (int d = N - 1; d >= 0; d--) begin
                for (int k = 0; k < len; k++) begin
                    put(d, (2048 + len * 64 + d * 16 + k) % 4096, k == 0, k == len - 1, 0);
                end
            end
        end
        rmode = 0;
        drain();
        // R8: fill destination 1 past its depth while every link is held off
        rmode = 2;
        repeat (2 * (CWD + 2)) @(posedge clk);
        #1;
        for (int k = 0; k < QD + 2; k++) begin
            put(1, 3000 + k, k == 0, k == QD + 1, 1);
        end
        repeat (4) @(posedge clk);
        #1;
        rmode = 0;
        drain();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule